// File: doc/BRIEF.md
# Serial Elastic FIFO

This block is a one-bit-wide elastic store that connects two unrelated clock domains. A producer pushes single bits on its own clock. A consumer takes them on a second clock that may be fully asynchronous to the first, or may be the same clock. The store holds `DEPTH` bits in a RAM, plus one more bit held in an output register.

The read side works in fall-through style. As soon as a bit reaches the read domain, it is loaded into the output register and `out_ready` rises. The consumer does not need to issue a read first. That presented bit no longer counts as stored. Both level flags measure only the bits still waiting in the RAM behind it. The read and write pointers cross between domains as Gray codes that carry one extra wrap bit. The read pointer passes through a 2-stage synchronizer into the write domain, and the write pointer passes through a 3-stage synchronizer into the read domain. As a result, the flags assert at once in the domain that causes them and clear only after the crossing latency.

The tri-state data output is modelled as a data bit plus a drive qualifier. The data bit reads 0 whenever the output is not enabled.

Top module: `serial_elastic_fifo`

## Requirements
- R1: While reset is applied and after it is released, with no writes, `in_ready` is 1, `out_ready` is 0, `half_full` is 0 and `almost_fe` is 1.
- R2: A bit is stored on a rising `wr_clk` edge only if `wr_en` and `in_ready` are both 1 at that edge. A bit offered while `in_ready` is 0 is dropped and never appears at the output.
- R3: Bits leave the output in the exact order in which they were accepted, with no loss and no duplication.
- R4: When a bit is accepted into an empty store, it is presented on `out_bit` with `out_ready` = 1 without any read request. `out_ready` and `out_bit` stay unchanged until that bit is consumed.
- R5: A bit is consumed on a rising `rd_clk` edge only if `rd_en` and `out_ready` are both 1 at that edge. While `out_ready` is 0, `rd_en` has no effect.
- R6: With the default `DEPTH` of 256 and no reads, exactly `DEPTH`+1 bits are accepted: 256 in the RAM and 1 presented. After that, `in_ready` stays 0.
- R7: Once the pointers have settled, `half_full` is 1 exactly when the stored count (accepted minus consumed, minus 1 if a bit is presented) is at least `DEPTH`/2.
- R8: Once the pointers have settled, `almost_fe` is 1 exactly when the stored count is at most `MARGIN` (8), or the number of free RAM locations (`DEPTH` minus the stored count) is at most `MARGIN`.
- R9: `out_drive` equals `out_en`. When `out_en` is 0, `out_bit` reads 0, and the presented bit and `out_ready` are unaffected.
- R10: With `RD_SYNC` = 3, a bit written into an empty store raises `out_ready` after exactly 4 rising `rd_clk` edges, counted from the write edge, provided no read edge coincides with a write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| wr_en | input | 1 | Offer `wr_bit` on this edge |
| wr_bit | input | 1 | Serial data in |
| in_ready | output | 1 | Room available; a write is taken only when this is high |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rd_en | input | 1 | Consume the presented bit on this edge |
| out_en | input | 1 | Output drive enable |
| out_ready | output | 1 | A bit is presented on the output |
| out_bit | output | 1 | Presented bit, forced to 0 when not driven |
| out_drive | output | 1 | Qualifier standing in for the tri-state: high when `out_bit` is driven |
| half_full | output | 1 | Stored count at least `DEPTH`/2 (read domain) |
| almost_fe | output | 1 | Stored count or free space within `MARGIN` (read domain) |

## Verification
The assertions assume the following about the inputs. Both resets are applied together and held across at least one edge of each clock. `wr_en`, `wr_bit`, `rd_en` and `out_en` change only away from the rising edge of their own clock. The bench meets these conditions by driving every input on the falling edge of its own clock. It runs the two clocks at 10 ns and 13 ns, so their rising edges never coincide, which makes the crossing latency of R10 deterministic. The level flags are compared only after the bench has left the pointers idle for long enough to cross.

// File: rtl/sef_pkg.sv
package sef_pkg;

  // Convert a Gray code of up to 32 bits back to binary.
  function automatic logic [31:0] gray_to_bin(logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int i = 1; i < 32; i++) b = b ^ (g >> i);
    return b;
  endfunction

  // Half-full threshold on the count of bits waiting behind the output.
  function automatic logic level_half(int unsigned stored, int unsigned depth);
    return stored >= (depth / 2);
  endfunction

  // Near-empty or near-full, merged into one flag.
  function automatic logic level_edge(int unsigned stored, int unsigned depth,
                                      int unsigned margin);
    return (stored <= margin) || ((depth - stored) <= margin);
  endfunction

endpackage

// File: rtl/sef_sync.sv
module sef_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sef_ram.sv
module sef_ram #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  logic mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wbit;
  end

  assign rbit = mem[raddr];
endmodule

// File: rtl/sef_wr_ctrl.sv
module sef_wr_ctrl
  import sef_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_s,
  output logic          in_ready,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray
);
  logic [PW-1:0] wbin, wbin_nxt, rbin_s, fill_nxt;

  assign rbin_s   = PW'(gray_to_bin(32'(rgray_s)));
  assign wr_fire  = wr_en & in_ready;
  assign wbin_nxt = wbin + PW'(wr_fire);
  assign fill_nxt = wbin_nxt - rbin_s;
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      in_ready <= 1'b1;
    end else begin
      wbin     <= wbin_nxt;
      wgray    <= wbin_nxt ^ (wbin_nxt >> 1);
      in_ready <= (fill_nxt != PW'(DEPTH));
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wbin - rbin_s) <= PW'(DEPTH)); // R6
  AST_IR_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_ready) |=> (wbin == $past(wbin))); // R2
  AST_WGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R3
endmodule

// File: rtl/sef_rd_ctrl.sv
module sef_rd_ctrl
  import sef_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int MARGIN = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_s,
  input  logic          ram_bit,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          out_ready,
  output logic          out_q,
  output logic          half_full,
  output logic          almost_fe
);
  logic [PW-1:0] rbin, rbin_nxt, wbin_s, avail, avail_nxt;
  logic          pop, load;

  assign wbin_s    = PW'(gray_to_bin(32'(wgray_s)));
  assign avail     = wbin_s - rbin;
  assign pop       = rd_en & out_ready;
  assign load      = (avail != '0) & (~out_ready | pop);
  assign rbin_nxt  = rbin + PW'(load);
  assign avail_nxt = wbin_s - rbin_nxt;
  assign raddr     = rbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      out_ready <= 1'b0;
      out_q     <= 1'b0;
      half_full <= 1'b0;
      almost_fe <= 1'b1;
    end else begin
      rbin      <= rbin_nxt;
      rgray     <= rbin_nxt ^ (rbin_nxt >> 1);
      out_ready <= load | (out_ready & ~pop);
      if (load) out_q <= ram_bit;
      half_full <= level_half(32'(avail_nxt), DEPTH);
      almost_fe <= level_edge(32'(avail_nxt), DEPTH, MARGIN);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    avail <= PW'(DEPTH)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !rd_en) |=> (out_ready && out_q == $past(out_q))); // R4
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && avail == '0) |=> !out_ready); // R5
  AST_RGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R3
endmodule

// File: rtl/serial_elastic_fifo.sv
module serial_elastic_fifo #(
  parameter int DEPTH   = 256,
  parameter int MARGIN  = 8,
  parameter int WR_SYNC = 2,
  parameter int RD_SYNC = 3
) (
  input  logic wr_clk,
  input  logic wr_rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic in_ready,
  input  logic rd_clk,
  input  logic rd_rst_n,
  input  logic rd_en,
  input  logic out_en,
  output logic out_ready,
  output logic out_bit,
  output logic out_drive,
  output logic half_full,
  output logic almost_fe
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          wr_fire, ram_bit, out_q;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

  sef_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .in_ready(in_ready), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray)
  );

  sef_ram #(.DEPTH(DEPTH)) u_ram (
    .wclk(wr_clk), .we(wr_fire), .waddr(waddr), .wbit(wr_bit),
    .raddr(raddr), .rbit(ram_bit)
  );

  sef_sync #(.W(PW), .STAGES(RD_SYNC)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s)
  );

  sef_sync #(.W(PW), .STAGES(WR_SYNC)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s)
  );

  sef_rd_ctrl #(.DEPTH(DEPTH), .MARGIN(MARGIN)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .ram_bit(ram_bit), .raddr(raddr), .rgray(rgray), .out_ready(out_ready),
    .out_q(out_q), .half_full(half_full), .almost_fe(almost_fe)
  );

  assign out_drive = out_en;
  assign out_bit   = out_en & out_q;

  AST_DRIVE_GATES_BIT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !out_drive |-> !out_bit); // R9
endmodule

// File: tb/serial_elastic_fifo_test.sv
`timescale 1ns/100ps
module serial_elastic_fifo_test;
  localparam int DEPTH  = 256;
  localparam int MARGIN = 8;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wr_en = 0, wr_bit = 0, rd_en = 0, out_en = 1;
  logic in_ready, out_ready, out_bit, out_drive, half_full, almost_fe;

  int tests = 0, fails = 0;
  bit model [$];

  always #5   wr_clk = ~wr_clk;
  always #6.5 rd_clk = ~rd_clk;

  serial_elastic_fifo uut (
    .wr_clk(wr_clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
    .in_ready(in_ready), .rd_clk(rd_clk), .rd_rst_n(rst_n), .rd_en(rd_en),
    .out_en(out_en), .out_ready(out_ready), .out_bit(out_bit),
    .out_drive(out_drive), .half_full(half_full), .almost_fe(almost_fe)
  );

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit pat(int i);
    return bit'(((i * 7) ^ (i >> 3) ^ (i >> 1)) & 1);
  endfunction

  // expected flags restated: doubling avoids the division
  task automatic check_levels(string tag);
    int stored = model.size() - (model.size() > 0 ? 1 : 0);
    check({tag, " R7 half_full"}, half_full, (2 * stored >= DEPTH) ? 1 : 0);
    check({tag, " R8 almost_fe"}, almost_fe,
          (stored <= MARGIN || stored + MARGIN >= DEPTH) ? 1 : 0);
  endtask

  task automatic pop_one(string tag);
    @(negedge rd_clk);
    check({tag, " R3 order"}, out_bit, model[0]);
    rd_en = 1;
    @(posedge rd_clk);
    void'(model.pop_front());
    @(negedge rd_clk);
    rd_en = 0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    int accepted;
    bit ir;
    // R1: reset state, during and after reset
    repeat (3) @(negedge rd_clk);
    check("R1 in_ready in reset", in_ready, 1);
    check("R1 out_ready in reset", out_ready, 0);
    rst_n = 1;
    repeat (4) @(negedge rd_clk);
    check("R1 in_ready", in_ready, 1);
    check("R1 out_ready", out_ready, 0);
    check("R1 half_full", half_full, 0);
    check("R1 almost_fe", almost_fe, 1);

    // R5: read requests on an empty store do nothing
    rd_en = 1;
    repeat (10) @(negedge rd_clk);
    check("R5 rd_en while empty", out_ready, 0);
    rd_en = 0;

    // R10 / R4: single bit, latency counted in read edges
    @(negedge wr_clk);
    wr_en = 1; wr_bit = 1;
    @(posedge wr_clk);
    model.push_back(1'b1);
    fork begin @(negedge wr_clk); wr_en = 0; end join_none
    n = 0;
    do begin
      @(posedge rd_clk); n++;
      @(negedge rd_clk);
    end while (!out_ready && n < 20);
    check("R10 read-edge latency", n, 4);
    check("R4 bit presented", out_bit, 1);
    repeat (20) @(negedge rd_clk);
    check("R4 out_ready held", out_ready, 1);
    check("R4 out_bit held", out_bit, 1);
    check_levels("single");

    // R9: output enable masks data but not state
    out_en = 0;
    @(negedge rd_clk);
    check("R9 out_drive off", out_drive, 0);
    check("R9 out_bit masked", out_bit, 0);
    check("R9 out_ready kept", out_ready, 1);
    out_en = 1;
    @(negedge rd_clk);
    check("R9 out_drive on", out_drive, 1);
    check("R9 bit restored", out_bit, 1);
    pop_one("single");
    repeat (3) @(negedge rd_clk);
    check("R5 empty after pop", out_ready, 0);

    // R6 / R2: fill with no reads, offering more than fits
    accepted = 0;
    for (int i = 0; i < 340; i++) begin
      @(negedge wr_clk);
      ir = in_ready;
      wr_en = 1; wr_bit = pat(i);
      @(posedge wr_clk);
      if (ir) begin model.push_back(pat(i)); accepted++; end
    end
    @(negedge wr_clk);
    wr_en = 0;
    repeat (10) @(negedge wr_clk);
    check("R6 accepted count", accepted, DEPTH + 1);
    check("R6 in_ready low when full", in_ready, 0);

    // R7 / R8 / R3 / R2: drain one bit at a time, every level
    while (model.size() > 0) begin
      repeat (3) @(negedge rd_clk);
      check("drain R4 out_ready", out_ready, 1);
      check_levels("drain");
      pop_one("drain");
    end
    repeat (4) @(negedge rd_clk);
    check("R5 drained", out_ready, 0);
    check_levels("drained");
    repeat (6) @(negedge wr_clk);
    check("R6 in_ready recovers", in_ready, 1);

    // R3: concurrent streaming with gaps on both sides
    begin
      bit wdone = 0;
      fork
        begin
          for (int i = 0; i < 700; i++) begin
            @(negedge wr_clk);
            ir = in_ready;
            wr_en = (i % 5 != 3); wr_bit = pat(i + 11);
            @(posedge wr_clk);
            if (ir && (i % 5 != 3)) model.push_back(pat(i + 11));
          end
          @(negedge wr_clk);
          wr_en = 0;
          wdone = 1;
        end
        begin
          int j = 0;
          while (!(wdone && model.size() == 0) && j < 5000) begin
            @(negedge rd_clk);
            if (out_ready && (j % 3 != 1)) begin
              check("stream R3 order", out_bit, model[0]);
              rd_en = 1;
              @(posedge rd_clk);
              void'(model.pop_front());
            end else begin
              rd_en = 0;
              @(posedge rd_clk);
            end
            j++;
          end
          @(negedge rd_clk);
          rd_en = 0;
        end
      join
    end
    repeat (6) @(negedge rd_clk);
    check("stream R3 all delivered", model.size(), 0);
    check("stream R5 empty", out_ready, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule